// File: doc/BRIEF.md
# Pulse Energy and Time Tally

This block turns the pulse train of a voltage-to-frequency converter into an energy figure. Each converter pulse adds one to a live energy count. A second live count advances once per microsecond strobe from the reference clock, so it acts as a time base. Both counts are free-running and wrap at their width, which is 32 bits by default.

A host issues one capture command. That command freezes both live counts into a pair of held registers on the same clock edge. The host then reads the two held values one at a time through a small register-select port. Because the pair was frozen together, an energy figure and its timestamp always belong to the same instant, even though the reads happen on different cycles. The energy used over an interval is the difference between two captured energy values. The elapsed time in microseconds is the difference between the matching captured time values. Both differences are taken modulo 2^width.

The converter pulse line is asynchronous. It is resynchronized and edge-detected before it is counted. A sticky flag tells software that at least one live count has wrapped since the flag was last cleared.

Top module: `pulse_energy_tally`

## Requirements
- R1: Each rising edge on `pulse_in` adds exactly one to the live energy count while `enable` is high, provided the pulse stays high and then low for at least three clocks each. The new count is in place no later than three clocks after the rising edge is first sampled.
- R2: Each clock cycle in which `tick` and `enable` are both high adds exactly one to the live time count.
- R3: A cycle with `capture` high copies both live counts into the held registers on the same edge. If an increment falls in the same cycle, the held value is the count from before that increment, and the increment still reaches the live count.
- R4: `rd_data` shows the held energy value when `rd_sel`=0 and the held time value when `rd_sel`=1. With `rd_sel`=2 it shows a status word whose bit 0 is the overflow flag and whose other bits are zero. With `rd_sel`=3 it shows zero. Held values change only on a capture.
- R5: While `enable` is low, both live counts keep their values and pulses and ticks are dropped. Capture and readback still work.
- R6: A cycle with `clear` high sets both live counts to zero and lowers the overflow flag. Clear wins over a simultaneous increment. The held registers are not affected.
- R7: An increment of a live count that holds all ones wraps that count to zero and raises `ovf_flag`. The flag then stays high until it is cleared.
- R8: A cycle with `rd_en` high and `rd_sel`=2 lowers `ovf_flag` on the next edge, unless a wrap happens in that same cycle, in which case the flag stays high.
- R9: After reset, both live counts, both held values and the overflow flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 1 | Asynchronous pulse line from the converter |
| tick | input | 1 | One-cycle strobe per reference period, synchronous to clk |
| enable | input | 1 | Counting enable |
| clear | input | 1 | Zero the live counts and the overflow flag |
| capture | input | 1 | Freeze both live counts into the held registers |
| rd_en | input | 1 | Read strobe; a strobe on the status word clears the flag |
| rd_sel | input | 2 | Register select: 0 energy, 1 time, 2 status, 3 zero |
| rd_data | output | CNT_W | Selected register value |
| ovf_flag | output | 1 | Sticky wrap indication |

## Verification
Several properties are checked on every cycle:
- Each counter steps by exactly one per accepted increment.
- Each counter holds while disabled and goes to zero after a clear.
- A single edge strobe never spans two cycles.
- The held pair equals the live pair from the cycle of a capture, and it stays put otherwise.
- The flag rises after a wrap and falls after a status read that has no wrap in the same cycle.

Other behaviour can only be shown by the bench's scenarios:
- An asynchronous pulse is counted exactly once, end to end.
- Intervals derived from two captures are correct across a wrap.
- Held values survive a clear.
- Pulses sent while disabled are lost for good.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef enum logic [1:0] {
    SEL_ENERGY = 2'd0,
    SEL_TIME   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } tally_sel_t;

  localparam int unsigned NUM_CNT  = 2;
  localparam int unsigned IDX_ENGY = 0;
  localparam int unsigned IDX_TIME = 1;
endpackage

// File: rtl/tally_edge_sync.sv
module tally_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LEN-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R1: one edge yields a single-cycle strobe
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tally_counter.sv
module tally_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = inc & ~clr & (&cnt_q);

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/tally_readmux.sv
module tally_readmux #(
  parameter int unsigned W = 32
) (
  input  tally_pkg::tally_sel_t sel,
  input  logic [W-1:0]          held_energy,
  input  logic [W-1:0]          held_time,
  input  logic                  ovf,
  output logic [W-1:0]          data
);
  import tally_pkg::*;

  logic [W-1:0] status_word;

  always_comb begin
    status_word    = '0;
    status_word[0] = ovf;
  end

  always_comb begin
    unique case (sel)
      SEL_ENERGY: data = held_energy;
      SEL_TIME:   data = held_time;
      SEL_STATUS: data = status_word;
      default:    data = '0;
    endcase
  end
endmodule

// File: rtl/pulse_energy_tally.sv
module pulse_energy_tally #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             tick,
  input  logic             enable,
  input  logic             clear,
  input  logic             capture,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             ovf_flag
);
  import tally_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // pulse front end
  logic pulse_rise;

  tally_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .async_in (pulse_in),
    .rise     (pulse_rise)
  );

  // live counters
  logic [NUM_CNT-1:0]  inc_v;
  logic [NUM_CNT-1:0]  wrap_v;
  logic [CNT_W-1:0]    live_v [NUM_CNT];

  assign inc_v[IDX_ENGY] = pulse_rise & enable;
  assign inc_v[IDX_TIME] = tick & enable;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tally_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_q_n),
      .clr   (clear),
      .inc   (inc_v[g]),
      .cnt   (live_v[g]),
      .wrap  (wrap_v[g])
    );
  end

  // held snapshot pair
  logic [CNT_W-1:0] held_q [NUM_CNT];
  logic [CNT_W-1:0] held_d [NUM_CNT];

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      held_d[i] = held_q[i];
      if (capture) held_d[i] = live_v[i];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int i = 0; i < NUM_CNT; i++) held_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) held_q[i] <= held_d[i];
    end
  end

  // sticky wrap flag
  logic ovf_q;
  logic ovf_d;
  logic status_rd;
  logic any_wrap;

  assign status_rd = rd_en & (tally_sel_t'(rd_sel) == SEL_STATUS);
  assign any_wrap  = |wrap_v;

  always_comb begin
    ovf_d = ovf_q;
    if (clear)          ovf_d = 1'b0;
    else if (any_wrap)  ovf_d = 1'b1;
    else if (status_rd) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ovf_q <= 1'b0;
    else          ovf_q <= ovf_d;
  end

  assign ovf_flag = ovf_q;

  tally_readmux #(.W(CNT_W)) u_rd (
    .sel         (tally_sel_t'(rd_sel)),
    .held_energy (held_q[IDX_ENGY]),
    .held_time   (held_q[IDX_TIME]),
    .ovf         (ovf_q),
    .data        (rd_data)
  );

  // checks next to the snapshot and flag logic
  p_atomic_pair_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    capture |=> (held_q[IDX_ENGY] == $past(live_v[IDX_ENGY]))
             && (held_q[IDX_TIME] == $past(live_v[IDX_TIME])));
  p_held_steady_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !capture |=> $stable(held_q[IDX_ENGY]) && $stable(held_q[IDX_TIME]));
  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!enable && !clear) |=> $stable(live_v[IDX_ENGY]) && $stable(live_v[IDX_TIME]));
  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (any_wrap && !clear) |=> ovf_flag);
  p_status_clears_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status_rd && !any_wrap) |=> !ovf_flag);
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    clear |=> !ovf_flag);
endmodule

// File: tb/test_pulse_energy_tally.sv
module test_pulse_energy_tally;
  localparam int unsigned W = 8;
  localparam int unsigned MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pulse_in = 1'b0;
  logic         tick = 1'b0;
  logic         enable = 1'b0;
  logic         clear = 1'b0;
  logic         capture = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_sel = 2'd0;
  logic [W-1:0] rd_data;
  logic         ovf_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_energy_tally #(.CNT_W(W)) i_pulse_energy_tally (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .tick(tick),
    .enable(enable), .clear(clear), .capture(capture), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  // vector fields: {enable, pulses[8:0], ticks[8:0]}
  localparam logic [18:0] VEC [7] = '{
    {1'b1, 9'd5,   9'd3},
    {1'b1, 9'd0,   9'd7},
    {1'b0, 9'd4,   9'd4},
    {1'b1, 9'd1,   9'd0},
    {1'b1, 9'd200, 9'd100},
    {1'b0, 9'd0,   9'd0},
    {1'b1, 9'd120, 9'd200}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pulse();
    @(negedge clk) pulse_in = 1'b1;
    repeat (3) @(negedge clk);
    pulse_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_capture();
    @(negedge clk) capture = 1'b1;
    @(negedge clk) capture = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output int val);
    @(negedge clk) rd_sel = sel;
    #1 val = int'(rd_data);
  endtask

  task automatic read_status(output int val);
    @(negedge clk) begin rd_sel = 2'd2; rd_en = 1'b1; end
    #1 val = int'(rd_data);
    @(negedge clk) rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int me, mt, pe, pt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    peek(2'd0, v); chk("R9 held energy", v, 0);
    peek(2'd1, v); chk("R9 held time", v, 0);
    peek(2'd2, v); chk("R9 status", v, 0);
    chk("R9 ovf_flag", int'(ovf_flag), 0);
    peek(2'd3, v); chk("R4 unused select", v, 0);

    // vector walk: R1 R2 R5 R3 R4 and interval differences
    me = 0; mt = 0; pe = 0; pt = 0;
    foreach (VEC[i]) begin
      @(negedge clk) enable = VEC[i][18];
      for (int k = 0; k < int'(VEC[i][17:9]); k++) send_pulse();
      for (int k = 0; k < int'(VEC[i][8:0]); k++) send_tick();
      if (VEC[i][18]) begin
        me = (me + int'(VEC[i][17:9])) % MOD;
        mt = (mt + int'(VEC[i][8:0])) % MOD;
      end
      do_capture();
      peek(2'd0, v); chk("R1 energy after vector", v, me);
      chk("R1 energy interval", (v - pe + MOD) % MOD,
          VEC[i][18] ? int'(VEC[i][17:9]) % MOD : 0);
      pe = v;
      peek(2'd1, v); chk("R2 time after vector", v, mt);
      chk("R5/R2 time interval", (v - pt + MOD) % MOD,
          VEC[i][18] ? int'(VEC[i][8:0]) % MOD : 0);
      pt = v;
    end

    // R4 held values steady while live counts move
    @(negedge clk) enable = 1'b1;
    send_pulse(); send_tick();
    peek(2'd0, v); chk("R4 held energy steady", v, me);
    peek(2'd1, v); chk("R4 held time steady", v, mt);

    // R6 clear zeros live counts, leaves held values
    do_clear();
    peek(2'd0, v); chk("R6 held survives clear", v, me);
    chk("R6 flag lowered", int'(ovf_flag), 0);
    do_capture();
    peek(2'd0, v); chk("R6 live energy zero", v, 0);
    peek(2'd1, v); chk("R6 live time zero", v, 0);

    // R6 clear wins over a same-cycle tick
    @(negedge clk) begin tick = 1'b1; clear = 1'b1; end
    @(negedge clk) begin tick = 1'b0; clear = 1'b0; end
    do_capture();
    peek(2'd1, v); chk("R6 clear beats tick", v, 0);

    // R3 capture with a same-cycle tick
    send_tick(); send_tick();
    @(negedge clk) begin tick = 1'b1; capture = 1'b1; end
    @(negedge clk) begin tick = 1'b0; capture = 1'b0; end
    peek(2'd1, v); chk("R3 held is pre-increment", v, 2);
    do_capture();
    peek(2'd1, v); chk("R3 increment kept in live", v, 3);

    // R5 disabled: pulses dropped, capture still works
    @(negedge clk) enable = 1'b0;
    send_pulse(); send_tick();
    do_capture();
    peek(2'd0, v); chk("R5 energy held while disabled", v, 0);
    peek(2'd1, v); chk("R5 time held while disabled", v, 3);
    @(negedge clk) enable = 1'b1;

    // R7 wrap sets sticky flag
    do_clear();
    for (int k = 0; k < 255; k++) send_tick();
    chk("R7 no flag before wrap", int'(ovf_flag), 0);
    send_tick();
    chk("R7 flag after wrap", int'(ovf_flag), 1);
    do_capture();
    peek(2'd1, v); chk("R7 count wrapped to zero", v, 0);
    send_tick();
    chk("R7 flag sticky", int'(ovf_flag), 1);

    // R8 status read clears flag
    read_status(v); chk("R8 status bit shows flag", v, 1);
    chk("R8 flag cleared by read", int'(ovf_flag), 0);
    peek(2'd2, v); chk("R8 status word now zero", v, 0);

    // R8 wrap in same cycle as status read keeps flag
    do_clear();
    for (int k = 0; k < 255; k++) send_tick();
    @(negedge clk) begin tick = 1'b1; rd_sel = 2'd2; rd_en = 1'b1; end
    @(negedge clk) begin tick = 1'b0; rd_en = 1'b0; end
    chk("R8 wrap beats status read", int'(ovf_flag), 1);

    // R7 energy wrap also sets flag
    do_clear();
    for (int k = 0; k < 256; k++) send_pulse();
    chk("R7 energy wrap flag", int'(ovf_flag), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule